// File: doc/BRIEF.md
# Linked-Descriptor DMA Chain Walker

The walker drives a DMA data mover from a linked list of transfer descriptors kept in memory. When it is told to start, it takes a first descriptor address from the register side. It reads that descriptor's control word to see whether hardware owns it. If hardware does, it fetches the remaining descriptor words and gives the transfer fields to the data mover through a request/done handshake. When the data mover finishes, the walker writes back the transferred byte count, the returned status byte and the updated control byte. It then follows the next-descriptor pointer.

A descriptor that hardware does not own ends the chain. In polling mode the walker instead waits a programmed number of clocks and reads the same descriptor again. A software reset abandons the walk at once. The walker emits one-cycle events for each finished descriptor, for the end of the chain, for end of packet and for error, so that an interrupt block elsewhere can use them.

Each descriptor is 32 bytes. The byte offsets are 0 for the read address, 8 for the write address and 16 for the next pointer, with a pad word after each. The word at offset 24 carries the length in bits 15:0, the read burst in bits 23:16 and the write burst in bits 31:24. The word at offset 28 carries the transferred count in bits 15:0, the status in bits 23:16 and the control byte in bits 31:24.

Top module: `sgw_chain_walker`

## Requirements
- R1: After reset the walker is idle: busy and every request output are 0, and no event output is set.
- R2: A start pulse while idle latches the first-descriptor address. The first memory read goes to that address plus 28, which is the control word. A memory request holds its address until it is acknowledged.
- R3: The transfer request presents the following fields. The read address comes from word offset 0 and the write address from offset 8. Length, read burst and write burst come from bits 15:0, 23:16 and 31:24 of offset 24. Read-fixed comes from control bit 1 and write-fixed from control bit 2. Read, write and transfer requests are never active together.
- R4: A descriptor with control bit 7 (hardware owned) clear, with polling off, causes no transfer and no write-back. It gives one chain-done event, and busy drops in the same cycle.
- R5: Write-back stores one word at descriptor offset 28: {control', status, transferred count}. When keep-ownership is 0, control' is the fetched control byte with bit 7 cleared.
- R6: When keep-ownership is 1, control' equals the fetched control byte unchanged.
- R7: After write-back the walker continues at the address in the descriptor's next pointer (offset 16).
- R8: In polling mode with gap N, a descriptor found unowned is read again. The read request stays low for exactly N+1 clocks between the two reads, and processing continues once ownership is set.
- R9: Status bits 0 to 5 are error bits. If any of them is set and stop-on-error is on, the walker goes idle right after that write-back, without a chain-done event. If stop-on-error is off, the walker carries on.
- R10: Each write-back gives a one-cycle descriptor-done event. The end-of-packet event fires when control bit 0 or status bit 7 is set. The error event fires when the status has an error bit set.
- R11: A software reset makes the walker idle one clock later and drops every pending request; a later start works normally.
- R12: Busy is 1 from the clock after an accepted start until the chain ends, halts on error, or is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_start | input | 1 | Begin walking (pulse, idle only) |
| ctl_sw_reset | input | 1 | Abort walk and return to idle |
| ctl_stop_on_err | input | 1 | Halt after a descriptor that reports an error |
| ctl_keep_own | input | 1 | 1 leaves the ownership bit set on write-back |
| ctl_poll_en | input | 1 | Re-poll unowned descriptors instead of stopping |
| ctl_poll_gap | input | POLL_W | Clocks to wait before re-polling |
| ctl_first_desc | input | ADDR_W | Address of the first descriptor |
| busy | output | 1 | Walk in progress |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Read byte address |
| mem_rd_ack | input | 1 | Read accepted, data valid |
| mem_rd_data | input | 32 | Read data |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_addr | output | ADDR_W | Write byte address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_ack | input | 1 | Write accepted |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_rd_addr | output | ADDR_W | Source address |
| xfer_wr_addr | output | ADDR_W | Destination address |
| xfer_len | output | 16 | Byte count |
| xfer_rd_burst | output | 8 | Read burst size |
| xfer_wr_burst | output | 8 | Write burst size |
| xfer_rd_fixed | output | 1 | Source address does not increment |
| xfer_wr_fixed | output | 1 | Destination address does not increment |
| xfer_done | input | 1 | Transfer finished |
| xfer_count | input | 16 | Bytes actually moved |
| xfer_status | input | 8 | Transfer status byte |
| evt_desc_done | output | 1 | Descriptor completed pulse |
| evt_chain_done | output | 1 | Chain completed pulse |
| evt_eop | output | 1 | End-of-packet pulse |
| evt_error | output | 1 | Error pulse |

## Verification
A wrong current-descriptor address shows on the next memory request: the read of the control word, or a write-back, goes to the wrong location within a few clocks. A wrong field index shows at the transfer handshake as a swapped address or length. A stale ownership or error decision shows up in several ways: a descriptor is processed that should not be, an event pulse is missing or extra, or busy drops or stays high within one clock of the write-back. The bench therefore checks memory contents after each walk, together with event counts, the captured transfer fields and exact poll gaps.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
   localparam int WORD_W       = 32;
   localparam int FIELD_WORDS  = 4;   // read addr, write addr, next, len/bursts
   localparam int STRIDE_B     = 8;   // data word plus pad word
   localparam int CTRL_OFS_B   = 28;  // count/status/control word
   localparam int CTL_LSB      = 24;
   localparam int OWN_BIT      = 7;
   localparam int EOP_BIT      = 0;
   localparam int RDFIX_BIT    = 1;
   localparam int WRFIX_BIT    = 2;
   localparam int RX_EOP_BIT   = 7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_CTL,
      ST_RD_FLD,
      ST_XFER,
      ST_WB,
      ST_POLL
   } walk_st_e;
endpackage

// File: rtl/sgw_desc_regs.sv
module sgw_desc_regs #(
   parameter int NWORDS = 4,
   parameter int WORD_W = 32,
   localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load,
   input  logic [IDX_W-1:0]              idx,
   input  logic [WORD_W-1:0]             din,
   output logic [NWORDS-1:0][WORD_W-1:0] words
);
   for (genvar g = 0; g < NWORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[g] <= '0;
         else if (load && idx == IDX_W'(g))
            words[g] <= din;
      end
   end
endmodule

// File: rtl/sgw_poll_timer.sv
module sgw_poll_timer #(
   parameter int GAP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic [GAP_W-1:0] gap,
   output logic             expired
);
   logic [GAP_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= '0;
      else if (load)
         cnt <= gap;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/sgw_wb_build.sv
module sgw_wb_build #(
   parameter int         CNT_W    = 16,
   parameter int         ST_W     = 8,
   parameter int         CTL_W    = 8,
   parameter logic [7:0] ERR_MASK = 8'h3F
) (
   input  logic [CTL_W-1:0]             ctrl_in,
   input  logic [CNT_W-1:0]             count,
   input  logic [ST_W-1:0]              status,
   input  logic                         keep_own,
   output logic [CTL_W+ST_W+CNT_W-1:0]  wb_word,
   output logic                         is_err,
   output logic                         is_eop
);
   import sgw_pkg::*;

   if (CNT_W + ST_W + CTL_W != WORD_W) begin : g_bad_pack
      $error("sgw_wb_build: packed write-back must fill one word");
   end
   if (ST_W != 8 || CTL_W != 8) begin : g_bad_bytes
      $error("sgw_wb_build: status and control are bytes");
   end

   logic [ST_W-1:0]  err_hits;
   logic [CTL_W-1:0] ctrl_out;

   for (genvar b = 0; b < ST_W; b++) begin : g_err
      if (ERR_MASK[b]) begin : g_on
         assign err_hits[b] = status[b];
      end else begin : g_off
         assign err_hits[b] = 1'b0;
      end
   end

   always_comb begin
      ctrl_out = ctrl_in;
      if (!keep_own)
         ctrl_out[OWN_BIT] = 1'b0;
   end

   assign is_err  = |err_hits;
   assign is_eop  = ctrl_in[EOP_BIT] | status[RX_EOP_BIT];
   assign wb_word = {ctrl_out, status, count};
endmodule

// File: rtl/sgw_chain_walker.sv
module sgw_chain_walker #(
   parameter int         ADDR_W   = 32,
   parameter int         POLL_W   = 8,
   parameter int         CNT_W    = 16,
   parameter logic [7:0] ERR_MASK = 8'h3F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_start,
   input  logic              ctl_sw_reset,
   input  logic              ctl_stop_on_err,
   input  logic              ctl_keep_own,
   input  logic              ctl_poll_en,
   input  logic [POLL_W-1:0] ctl_poll_gap,
   input  logic [ADDR_W-1:0] ctl_first_desc,
   output logic              busy,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_ack,
   input  logic [31:0]       mem_rd_data,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [31:0]       mem_wr_data,
   input  logic              mem_wr_ack,
   output logic              xfer_req,
   output logic [ADDR_W-1:0] xfer_rd_addr,
   output logic [ADDR_W-1:0] xfer_wr_addr,
   output logic [15:0]       xfer_len,
   output logic [7:0]        xfer_rd_burst,
   output logic [7:0]        xfer_wr_burst,
   output logic              xfer_rd_fixed,
   output logic              xfer_wr_fixed,
   input  logic              xfer_done,
   input  logic [CNT_W-1:0]  xfer_count,
   input  logic [7:0]        xfer_status,
   output logic              evt_desc_done,
   output logic              evt_chain_done,
   output logic              evt_eop,
   output logic              evt_error
);
   import sgw_pkg::*;

   localparam int IDX_W     = $clog2(FIELD_WORDS);
   localparam int STRIDE_SH = $clog2(STRIDE_B);
   localparam int LAST_FLD  = FIELD_WORDS - 1;
   localparam int ST_W      = 8;
   localparam int CTL_W     = 8;

   if (ADDR_W < 6 || ADDR_W > WORD_W) begin : g_bad_addr
      $error("sgw_chain_walker: ADDR_W must lie in 6..32");
   end
   if (POLL_W < 1) begin : g_bad_poll
      $error("sgw_chain_walker: POLL_W must be positive");
   end
   if (CNT_W != 16) begin : g_bad_cnt
      $error("sgw_chain_walker: descriptor count field is 16 bits");
   end

   walk_st_e                        st;
   logic [ADDR_W-1:0]               cur_addr;
   logic [IDX_W-1:0]                fld_idx;
   logic [CTL_W-1:0]                ctl_byte;
   logic [CNT_W-1:0]                got_cnt;
   logic [ST_W-1:0]                 got_status;
   logic [FIELD_WORDS-1:0][WORD_W-1:0] fld;
   logic                            fld_load;
   logic                            tmr_load;
   logic                            tmr_expired;
   logic                            rd_owned;
   logic [WORD_W-1:0]               wb_word;
   logic                            wb_err;
   logic                            wb_eop;
   logic [ADDR_W-1:0]               ctl_word_addr;
   logic [ADDR_W-1:0]               fld_addr;

   assign rd_owned = mem_rd_data[CTL_LSB + OWN_BIT];
   assign fld_load = (st == ST_RD_FLD) && mem_rd_ack;
   assign tmr_load = (st == ST_RD_CTL) && mem_rd_ack && !rd_owned && ctl_poll_en;

   sgw_desc_regs #(
      .NWORDS (FIELD_WORDS),
      .WORD_W (WORD_W)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (fld_load),
      .idx   (fld_idx),
      .din   (mem_rd_data),
      .words (fld)
   );

   sgw_poll_timer #(
      .GAP_W (POLL_W)
   ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (ctl_sw_reset),
      .load    (tmr_load),
      .gap     (ctl_poll_gap),
      .expired (tmr_expired)
   );

   sgw_wb_build #(
      .CNT_W    (CNT_W),
      .ST_W     (ST_W),
      .CTL_W    (CTL_W),
      .ERR_MASK (ERR_MASK)
   ) u_wb (
      .ctrl_in  (ctl_byte),
      .count    (got_cnt),
      .status   (got_status),
      .keep_own (ctl_keep_own),
      .wb_word  (wb_word),
      .is_err   (wb_err),
      .is_eop   (wb_eop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st             <= ST_IDLE;
         cur_addr       <= '0;
         fld_idx        <= '0;
         ctl_byte       <= '0;
         got_cnt        <= '0;
         got_status     <= '0;
         evt_desc_done  <= 1'b0;
         evt_chain_done <= 1'b0;
         evt_eop        <= 1'b0;
         evt_error      <= 1'b0;
      end else begin
         evt_desc_done  <= 1'b0;
         evt_chain_done <= 1'b0;
         evt_eop        <= 1'b0;
         evt_error      <= 1'b0;
         if (ctl_sw_reset) begin
            st      <= ST_IDLE;
            fld_idx <= '0;
         end else begin
            unique case (st)
               ST_IDLE: begin
                  if (ctl_start) begin
                     cur_addr <= ctl_first_desc;
                     st       <= ST_RD_CTL;
                  end
               end
               ST_RD_CTL: begin
                  if (mem_rd_ack) begin
                     ctl_byte <= mem_rd_data[CTL_LSB +: CTL_W];
                     if (rd_owned) begin
                        fld_idx <= '0;
                        st      <= ST_RD_FLD;
                     end else if (ctl_poll_en) begin
                        st <= ST_POLL;
                     end else begin
                        evt_chain_done <= 1'b1;
                        st             <= ST_IDLE;
                     end
                  end
               end
               ST_RD_FLD: begin
                  if (mem_rd_ack) begin
                     if (fld_idx == IDX_W'(LAST_FLD))
                        st <= ST_XFER;
                     else
                        fld_idx <= fld_idx + 1'b1;
                  end
               end
               ST_XFER: begin
                  if (xfer_done) begin
                     got_cnt    <= xfer_count;
                     got_status <= xfer_status;
                     st         <= ST_WB;
                  end
               end
               ST_WB: begin
                  if (mem_wr_ack) begin
                     evt_desc_done <= 1'b1;
                     evt_eop       <= wb_eop;
                     evt_error     <= wb_err;
                     if (wb_err && ctl_stop_on_err) begin
                        st <= ST_IDLE;
                     end else begin
                        cur_addr <= fld[2][ADDR_W-1:0];
                        st       <= ST_RD_CTL;
                     end
                  end
               end
               ST_POLL: begin
                  if (tmr_expired)
                     st <= ST_RD_CTL;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assign ctl_word_addr = cur_addr + ADDR_W'(CTRL_OFS_B);
   assign fld_addr      = cur_addr + (ADDR_W'(fld_idx) << STRIDE_SH);

   assign busy        = (st != ST_IDLE);
   assign mem_rd_req  = (st == ST_RD_CTL) || (st == ST_RD_FLD);
   assign mem_rd_addr = (st == ST_RD_CTL) ? ctl_word_addr : fld_addr;
   assign mem_wr_req  = (st == ST_WB);
   assign mem_wr_addr = ctl_word_addr;
   assign mem_wr_data = wb_word;

   assign xfer_req      = (st == ST_XFER);
   assign xfer_rd_addr  = fld[0][ADDR_W-1:0];
   assign xfer_wr_addr  = fld[1][ADDR_W-1:0];
   assign xfer_len      = fld[3][15:0];
   assign xfer_rd_burst = fld[3][23:16];
   assign xfer_wr_burst = fld[3][31:24];
   assign xfer_rd_fixed = ctl_byte[RDFIX_BIT];
   assign xfer_wr_fixed = ctl_byte[WRFIX_BIT];
endmodule

// File: rtl/sgw_walker_chk.sv
module sgw_walker_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_sw_reset,
   input logic              ctl_stop_on_err,
   input logic              ctl_keep_own,
   input logic              busy,
   input logic              mem_rd_req,
   input logic              mem_rd_ack,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_wr_req,
   input logic [31:0]       mem_wr_data,
   input logic              xfer_req,
   input logic              evt_desc_done,
   input logic              evt_chain_done,
   input logic              evt_error
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_rd_req && !mem_wr_req && !xfer_req);

   assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || ctl_sw_reset)
      mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr));

   assert_one_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd_req, mem_wr_req, xfer_req}));

   assert_chain_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_chain_done |-> !busy);

   assert_wb_own_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req && !ctl_keep_own |-> !mem_wr_data[31]);

   assert_err_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_error && ctl_stop_on_err |-> !busy && !evt_chain_done);

   assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      evt_desc_done |=> !evt_desc_done);

   assert_swrst_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_sw_reset |=> !busy && !mem_rd_req && !mem_wr_req && !xfer_req);
endmodule

bind sgw_chain_walker sgw_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .ctl_sw_reset    (ctl_sw_reset),
   .ctl_stop_on_err (ctl_stop_on_err),
   .ctl_keep_own    (ctl_keep_own),
   .busy            (busy),
   .mem_rd_req      (mem_rd_req),
   .mem_rd_ack      (mem_rd_ack),
   .mem_rd_addr     (mem_rd_addr),
   .mem_wr_req      (mem_wr_req),
   .mem_wr_data     (mem_wr_data),
   .xfer_req        (xfer_req),
   .evt_desc_done   (evt_desc_done),
   .evt_chain_done  (evt_chain_done),
   .evt_error       (evt_error)
);

// File: tb/sgw_chain_walker_tb.sv
module sgw_chain_walker_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_start = 1'b0, ctl_sw_reset = 1'b0, ctl_stop_on_err = 1'b0;
   logic        ctl_keep_own = 1'b0, ctl_poll_en = 1'b0;
   logic [7:0]  ctl_poll_gap = 8'd0;
   logic [31:0] ctl_first_desc = 32'd0;
   logic        busy, mem_rd_req, mem_wr_req, xfer_req;
   logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
   logic        mem_rd_ack = 1'b0, mem_wr_ack = 1'b0;
   logic [31:0] mem_rd_data = 32'd0;
   logic [31:0] xfer_rd_addr, xfer_wr_addr;
   logic [15:0] xfer_len;
   logic [7:0]  xfer_rd_burst, xfer_wr_burst;
   logic        xfer_rd_fixed, xfer_wr_fixed;
   logic        xfer_done = 1'b0;
   logic [15:0] xfer_count = 16'd0;
   logic [7:0]  xfer_status = 8'd0;
   logic        evt_desc_done, evt_chain_done, evt_eop, evt_error;

   always #2 clk = ~clk;

   sgw_chain_walker u_dut (.*);

   int checks = 0, errors = 0;
   logic [31:0] mem [0:63];
   int xfer_n = 0, err_at = -1, dp_wait = 0;
   int n_done = 0, n_chain = 0, n_eop = 0, n_err = 0;
   logic [31:0] log_ra [0:15], log_wa [0:15];
   logic [15:0] log_len [0:15];
   logic [7:0]  log_rb [0:15], log_wb [0:15];
   logic        log_rf [0:15], log_wf [0:15];

   // memory model: one-cycle acknowledge
   always @(posedge clk) begin
      mem_rd_ack <= mem_rd_req && !mem_rd_ack;
      if (mem_rd_req && !mem_rd_ack) mem_rd_data <= mem[mem_rd_addr[7:2]];
      mem_wr_ack <= mem_wr_req && !mem_wr_ack;
      if (mem_wr_req && !mem_wr_ack) mem[mem_wr_addr[7:2]] <= mem_wr_data;
   end

   // data mover model
   always @(posedge clk) begin
      xfer_done <= 1'b0;
      if (xfer_req && !xfer_done) begin
         if (dp_wait == 2) begin
            xfer_done   <= 1'b1;
            xfer_count  <= xfer_len;
            xfer_status <= (xfer_n == err_at) ? 8'h05 : 8'h00;
            log_ra[xfer_n[3:0]]  <= xfer_rd_addr;
            log_wa[xfer_n[3:0]]  <= xfer_wr_addr;
            log_len[xfer_n[3:0]] <= xfer_len;
            log_rb[xfer_n[3:0]]  <= xfer_rd_burst;
            log_wb[xfer_n[3:0]]  <= xfer_wr_burst;
            log_rf[xfer_n[3:0]]  <= xfer_rd_fixed;
            log_wf[xfer_n[3:0]]  <= xfer_wr_fixed;
            xfer_n  <= xfer_n + 1;
            dp_wait <= 0;
         end else dp_wait <= dp_wait + 1;
      end else if (!xfer_req) dp_wait <= 0;
   end

   always @(posedge clk) begin
      if (evt_desc_done)  n_done  <= n_done + 1;
      if (evt_chain_done) n_chain <= n_chain + 1;
      if (evt_eop)        n_eop   <= n_eop + 1;
      if (evt_error)      n_err   <= n_err + 1;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put_desc(input int s, input logic [31:0] ra, input logic [31:0] wa,
                           input int nxt, input logic [15:0] len, input logic [7:0] rb,
                           input logic [7:0] wb, input logic [7:0] ctl);
      mem[8*s+0] = ra; mem[8*s+1] = 32'hDEAD0001;
      mem[8*s+2] = wa; mem[8*s+3] = 32'hDEAD0003;
      mem[8*s+4] = 32'(32*nxt); mem[8*s+5] = 32'hDEAD0005;
      mem[8*s+6] = {wb, rb, len};
      mem[8*s+7] = {ctl, 8'h00, 16'h0000};
   endtask

   task automatic pulse_start(input int s);
      ctl_first_desc = 32'(32*s);
      @(negedge clk) ctl_start = 1'b1;
      @(negedge clk) ctl_start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic build_chain();
      put_desc(0, 32'h1000, 32'h2000, 1, 16'd100, 8'h04, 8'h08, 8'h83);
      put_desc(1, 32'h1100, 32'h2100, 2, 16'd200, 8'h10, 8'h20, 8'h84);
      put_desc(2, 32'h1200, 32'h2200, 3, 16'd300, 8'h01, 8'h02, 8'h81);
      put_desc(3, 32'h1300, 32'h2300, 4, 16'd400, 8'h01, 8'h01, 8'h00);
   endtask

   task automatic t_reset();
      check("R1 busy", 32'(busy), 0);
      check("R1 reqs", {29'd0, mem_rd_req, mem_wr_req, xfer_req}, 0);
      check("R1 events", {28'd0, evt_desc_done, evt_chain_done, evt_eop, evt_error}, 0);
   endtask

   task automatic t_basic();
      int d0, c0, e0, r0, x0;
      build_chain();
      ctl_keep_own = 1'b0; ctl_stop_on_err = 1'b0;
      d0 = n_done; c0 = n_chain; e0 = n_eop; r0 = n_err; x0 = xfer_n;
      pulse_start(0);
      check("R12 busy after start", 32'(busy), 1);
      check("R2 first read addr", mem_rd_addr, 32'd28);
      check("R2 first read req", 32'(mem_rd_req), 1);
      wait_idle();
      check("R12 busy at end", 32'(busy), 0);
      check("R10 desc done count", n_done - d0, 3);
      check("R4 chain done count", n_chain - c0, 1);
      check("R10 eop count", n_eop - e0, 2);
      check("R10 err count", n_err - r0, 0);
      check("R3 xfer0 raddr", log_ra[x0[3:0]], 32'h1000);
      check("R3 xfer0 waddr", log_wa[x0[3:0]], 32'h2000);
      check("R3 xfer0 len/bursts", {log_wb[x0[3:0]], log_rb[x0[3:0]], log_len[x0[3:0]]}, {8'h08, 8'h04, 16'd100});
      check("R3 xfer0 fixed", {30'd0, log_wf[x0[3:0]], log_rf[x0[3:0]]}, 32'b01);
      check("R3 xfer1 fixed", {30'd0, log_wf[(x0+1)%16], log_rf[(x0+1)%16]}, 32'b10);
      check("R5 wb slot0", mem[7], {8'h03, 8'h00, 16'd100});
      check("R7 wb slot1", mem[15], {8'h04, 8'h00, 16'd200});
      check("R7 wb slot2", mem[23], {8'h01, 8'h00, 16'd300});
      check("R4 unowned slot3 untouched", mem[31], 32'h0);
      check("R4 xfer count", xfer_n - x0, 3);
   endtask

   task automatic t_keep();
      build_chain();
      ctl_keep_own = 1'b1;
      pulse_start(0);
      wait_idle();
      // owned descriptors stay owned; slot 3 ends the chain
      check("R6 keep slot0", mem[7], {8'h83, 8'h00, 16'd100});
      check("R6 keep slot2", mem[23], {8'h81, 8'h00, 16'd300});
      ctl_keep_own = 1'b0;
   endtask

   task automatic t_stop_err(input logic stop);
      int d0, c0, r0;
      build_chain();
      ctl_stop_on_err = stop;
      err_at = xfer_n + 1;
      d0 = n_done; c0 = n_chain; r0 = n_err;
      pulse_start(0);
      wait_idle();
      check("R9 err count", n_err - r0, 1);
      check("R9 slot1 status", mem[15], {8'h04, 8'h05, 16'd200});
      if (stop) begin
         check("R9 halt desc count", n_done - d0, 2);
         check("R9 halt no chain evt", n_chain - c0, 0);
         check("R9 slot2 untouched", mem[23], {8'h81, 8'h00, 16'h0000});
      end else begin
         check("R9 continue desc count", n_done - d0, 3);
         check("R9 continue chain evt", n_chain - c0, 1);
         check("R9 slot2 written", mem[23], {8'h01, 8'h00, 16'd300});
      end
      err_at = -1;
      ctl_stop_on_err = 1'b0;
   endtask

   task automatic t_unowned();
      int d0, c0, x0;
      put_desc(5, 32'h5000, 32'h6000, 6, 16'd50, 8'h01, 8'h01, 8'h01);
      d0 = n_done; c0 = n_chain; x0 = xfer_n;
      pulse_start(5);
      wait_idle();
      check("R4 no desc done", n_done - d0, 0);
      check("R4 chain evt", n_chain - c0, 1);
      check("R4 no transfer", xfer_n - x0, 0);
      check("R4 no write-back", mem[47], {8'h01, 8'h00, 16'h0000});
   endtask

   task automatic t_poll(input logic [7:0] gap);
      int lows, d0;
      put_desc(6, 32'h7000, 32'h7100, 7, 16'd64, 8'h02, 8'h02, 8'h00);
      put_desc(7, 32'h7200, 32'h7300, 7, 16'd64, 8'h02, 8'h02, 8'h00);
      ctl_poll_en = 1'b1; ctl_poll_gap = gap;
      d0 = n_done;
      pulse_start(6);
      for (int i = 0; i < 50 && !mem_rd_req; i++) @(negedge clk);
      for (int i = 0; i < 50 && mem_rd_req; i++) @(negedge clk);
      lows = 0;
      for (int i = 0; i < 300 && !mem_rd_req; i++) begin lows++; @(negedge clk); end
      check("R8 poll gap", lows, 32'(gap) + 1);
      mem[55] = {8'h80, 8'h00, 16'h0000};
      for (int i = 0; i < 400 && n_done == d0; i++) @(negedge clk);
      check("R8 processed after own", n_done - d0, 1);
      check("R8 wb after poll", mem[55], {8'h00, 8'h00, 16'd64});
      check("R8 still polling", 32'(busy), 1);
      @(negedge clk) ctl_sw_reset = 1'b1;
      @(negedge clk) ctl_sw_reset = 1'b0;
      ctl_poll_en = 1'b0;
   endtask

   task automatic t_swreset();
      int d0;
      build_chain();
      pulse_start(0);
      for (int i = 0; i < 100 && !xfer_req; i++) @(negedge clk);
      check("R11 reached transfer", 32'(xfer_req), 1);
      ctl_sw_reset = 1'b1;
      @(negedge clk) ctl_sw_reset = 1'b0;
      check("R11 idle next clock", {29'd0, busy, xfer_req, mem_rd_req}, 0);
      repeat (5) @(negedge clk);
      check("R11 no write-back", mem[7], {8'h83, 8'h00, 16'h0000});
      d0 = n_done;
      pulse_start(0);
      wait_idle();
      check("R11 restart works", n_done - d0, 3);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 32'h0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_basic();
      t_keep();
      t_stop_err(1'b1);
      t_stop_err(1'b0);
      t_unowned();
      t_poll(8'd5);
      t_poll(8'd0);
      t_swreset();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule